// File: doc/BRIEF.md
# Sixteen-Bit Modulo Timer Counter

This block is a sixteen-bit up-counter that runs from zero to a programmable limit and then starts again at zero. Software reaches it through a small byte-wide register port. The limit is split into an upper byte and a lower byte. The counter advances only on cycles where an external prescaled enable is high. When a counting cycle finds the count equal to the limit, the count goes back to zero and an overflow flag is raised. The flag can drive an interrupt request line.

The limit is changed as a pair. A write to the upper byte only stages that byte and opens a pending window. The new sixteen-bit limit takes effect when the lower byte is written. While the window is open, overflow events still wrap the count, but they cannot raise the flag, and the interrupt line is held low. Software is expected to clear the counter through the control register before it changes the limit.

Top module: `mod_timer16`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, both count bytes read 0x00, both limit bytes (addresses 3 and 4) read 0xFF, any address above 4 reads 0x00, and the interrupt line is low.
- R2: On each cycle with `cnt_en` high and the stop bit clear, the count (upper byte at address 1, lower byte at address 2) rises by one; on cycles with `cnt_en` low it holds.
- R3: When a counting cycle finds the count equal to the active limit, the count becomes zero at that edge, and the overflow flag (control bit 7) reads 1 from the next cycle.
- R4: A write to address 3 stages the upper limit byte, which address 3 then reads back, and leaves the active limit unchanged; a later write to address 4 makes the active limit {staged byte, written byte}.
- R5: From a write to address 3 until the next write to address 4, wraps still clear the count but do not set the overflow flag.
- R6: The interrupt line `ovf_irq` is high exactly when the overflow flag is 1, the enable bit (control bit 6) is 1, and no upper-byte write is pending.
- R7: The overflow flag clears only through a control write with bit 7 at 0 that follows a control read made while the flag was 1, with no other control write in between; writing 1 to bit 7 has no effect.
- R8: If a flag-setting wrap and a flag-clearing control write fall in the same cycle, the flag stays 1.
- R9: A control write with bit 4 at 1 clears the count to zero. This wins over counting and suppresses any wrap in that cycle. Bit 4 always reads 0.
- R10: While the stop bit (control bit 5) is 1, the count holds even with `cnt_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Prescaled count enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from the address) |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
Two pairs of events can land in the same cycle. The first is a wrap that sets the flag while software's clear write arrives. The bench arms the clear with a control read, counts up to one below the wrap, and then issues the clearing write on the wrapping tick; the flag must then read back as 1. The second is a wrap while an upper-byte write is pending. The bench runs the count through the limit inside the pending window and expects the count at zero with the flag still clear. The random phase mixes both situations with counter clears and stop toggles. It judges each read and each cycle's interrupt level against a bench model.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_LIM_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_LIM_LO = 3'd4;

  localparam int unsigned B_FLAG = 7;
  localparam int unsigned B_IE   = 6;
  localparam int unsigned B_STOP = 5;
  localparam int unsigned B_CLR  = 4;
endpackage

// File: rtl/tmr_limit_regs.sv
module tmr_limit_regs #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned LIM_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] stage_hi,
  output logic [LIM_W-1:0]  limit,
  output logic              pend
);
  logic [BYTE_W-1:0] stage_d;
  logic [LIM_W-1:0]  limit_d;
  logic              pend_d;

  always_comb begin
    stage_d = stage_hi;
    limit_d = limit;
    pend_d  = pend;
    if (wr_hi) begin
      stage_d = wdata;
      pend_d  = 1'b1;
    end else if (wr_lo) begin
      limit_d = {stage_hi, wdata};
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_hi <= '1;
      limit    <= '1;
      pend     <= 1'b0;
    end else begin
      stage_hi <= stage_d;
      limit    <= limit_d;
      pend     <= pend_d;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] count_d;

  always_comb begin
    wrap    = tick && !clr && (count == limit);
    count_d = count;
    if (clr || wrap) begin
      count_d = '0;
    end else if (tick) begin
      count_d = count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      count <= count_d;
    end
  end
endmodule

// File: rtl/tmr_ovf_flag.sv
module tmr_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic ctrl_rd,
  input  logic ctrl_wr,
  input  logic wr_flag_bit,
  output logic flag
);
  logic arm_q, arm_d, flag_d, clear_req;

  always_comb begin
    clear_req = ctrl_wr && !wr_flag_bit && arm_q;
    arm_d = arm_q;
    if (ctrl_rd && flag) begin
      arm_d = 1'b1;
    end else if (ctrl_wr) begin
      arm_d = 1'b0;
    end
    flag_d = flag;
    if (set_req) begin
      flag_d = 1'b1;
    end else if (clear_req) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      flag  <= 1'b0;
    end else begin
      arm_q <= arm_d;
      flag  <= flag_d;
    end
  end
endmodule

// File: rtl/mod_timer16.sv
module mod_timer16
  import timer_pkg::*;
#(
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned AW = ADDR_W,
  localparam int unsigned CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          ovf_irq
);
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_s = rst_pipe[1];

  logic ctrl_wr, ctrl_rd, lim_hi_wr, lim_lo_wr;
  logic ie_q, stop_q, ie_d, stop_d;
  logic tick, cnt_clr, wrap, pend, flag;
  logic [CW-1:0] count, limit;
  logic [DW-1:0] stage_hi;

  always_comb begin
    ctrl_wr   = bus_wr && (bus_addr == AW'(A_CTRL));
    ctrl_rd   = bus_rd && (bus_addr == AW'(A_CTRL));
    lim_hi_wr = bus_wr && (bus_addr == AW'(A_LIM_HI));
    lim_lo_wr = bus_wr && (bus_addr == AW'(A_LIM_LO));
    tick      = cnt_en && !stop_q;
    cnt_clr   = ctrl_wr && bus_wdata[B_CLR];
    ie_d      = ctrl_wr ? bus_wdata[B_IE]   : ie_q;
    stop_d    = ctrl_wr ? bus_wdata[B_STOP] : stop_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ie_q   <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      ie_q   <= ie_d;
      stop_q <= stop_d;
    end
  end

  tmr_limit_regs #(.BYTE_W(DW)) u_lim (
    .clk(clk), .rst_n(rst_s), .wr_hi(lim_hi_wr), .wr_lo(lim_lo_wr),
    .wdata(bus_wdata), .stage_hi(stage_hi), .limit(limit), .pend(pend)
  );

  tmr_counter #(.CNT_W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_s), .tick(tick), .clr(cnt_clr),
    .limit(limit), .count(count), .wrap(wrap)
  );

  tmr_ovf_flag u_flag (
    .clk(clk), .rst_n(rst_s), .set_req(wrap && !pend),
    .ctrl_rd(ctrl_rd), .ctrl_wr(ctrl_wr),
    .wr_flag_bit(bus_wdata[B_FLAG]), .flag(flag)
  );

  assign ovf_irq = flag && ie_q && !pend;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(A_CTRL): begin
        bus_rdata[B_FLAG] = flag;
        bus_rdata[B_IE]   = ie_q;
        bus_rdata[B_STOP] = stop_q;
      end
      AW'(A_CNT_HI): bus_rdata = count[CW-1:DW];
      AW'(A_CNT_LO): bus_rdata = count[DW-1:0];
      AW'(A_LIM_HI): bus_rdata = stage_hi;
      AW'(A_LIM_LO): bus_rdata = limit[DW-1:0];
      default:       bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mod_timer16_chk.sv
module mod_timer16_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          tick,
  input logic          clr,
  input logic          pend,
  input logic          flag,
  input logic          wr_hi,
  input logic          wr_lo,
  input logic [CW-1:0] count,
  input logic [CW-1:0] limit
);
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick && !clr && !pend && count == limit) |=> (count == '0 && flag));

  assert_hold_flag_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend && !flag) |=> !flag);

  assert_stage_only_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_hi && !wr_lo) |=> $stable(limit));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (count == '0));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tick && !clr) |=> $stable(count));
endmodule

bind mod_timer16 mod_timer16_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_ni(rst_s), .tick(tick), .clr(cnt_clr), .pend(pend),
  .flag(flag), .wr_hi(lim_hi_wr), .wr_lo(lim_lo_wr),
  .count(count), .limit(limit)
);

// File: tb/mod_timer16_test.sv
module mod_timer16_test;
  logic       clk, rst_n, cnt_en, bus_wr, bus_rd, ovf_irq;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  int total = 0, bad = 0;
  bit done = 0;

  mod_timer16 uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ovf_irq(ovf_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Bench model state
  logic [15:0] m_cnt, m_lim;
  logic [7:0]  m_stage;
  bit m_pend, m_flag, m_ie, m_stop, m_arm;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(logic [2:0] a);
    case (a)
      3'd0: return {m_flag, m_ie, m_stop, 5'b0};
      3'd1: return m_cnt[15:8];
      3'd2: return m_cnt[7:0];
      3'd3: return m_stage;
      3'd4: return m_lim[7:0];
      default: return 8'h00;
    endcase
  endfunction

  // One clock: drive, check the interrupt level, advance the model.
  task automatic step(bit wr, bit rd, logic [2:0] a, logic [7:0] d, bit en);
    bit tick, clr, wrap, setf, clrf, cw;
    logic [15:0] n_cnt;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; cnt_en = en;
    #1;
    check("R6 irq", {15'b0, ovf_irq}, {15'b0, m_flag & m_ie & ~m_pend});
    if (rd) check("R1-R10 read model", {8'b0, bus_rdata}, {8'b0, model_rd(a)});
    cw   = wr && a == 3'd0;
    tick = en && !m_stop;
    clr  = cw && d[4];
    wrap = tick && !clr && m_cnt == m_lim;
    setf = wrap && !m_pend;
    clrf = cw && !d[7] && m_arm;
    n_cnt = clr || wrap ? 16'h0 : (tick ? m_cnt + 16'h1 : m_cnt);
    @(posedge clk);
    m_cnt = n_cnt;
    if (rd && a == 3'd0 && m_flag) m_arm = 1; else if (cw) m_arm = 0;
    if (setf) m_flag = 1; else if (clrf) m_flag = 0;
    if (cw) begin m_ie = d[6]; m_stop = d[5]; end
    if (wr && a == 3'd3) begin m_stage = d; m_pend = 1; end
    else if (wr && a == 3'd4) begin m_lim = {m_stage, d}; m_pend = 0; end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; cnt_en = 0;
  endtask

  task automatic rdx(logic [2:0] a, logic [7:0] exp, string tag);
    bus_addr = a; #1;
    check(tag, {8'b0, bus_rdata}, {8'b0, exp});
    step(0, 1, a, 8'h00, 0);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    step(1, 0, a, d, 0);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(0, 0, 3'd0, 8'h00, 1);
  endtask

  initial begin
    #150000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 0; cnt_en = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    m_cnt = 0; m_lim = 16'hFFFF; m_stage = 8'hFF;
    m_pend = 0; m_flag = 0; m_ie = 0; m_stop = 0; m_arm = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 irq", {15'b0, ovf_irq}, 16'h0);
    rdx(3'd0, 8'h00, "R1 ctrl");
    rdx(3'd1, 8'h00, "R1 cnt hi");
    rdx(3'd2, 8'h00, "R1 cnt lo");
    rdx(3'd3, 8'hFF, "R1 lim hi");
    rdx(3'd4, 8'hFF, "R1 lim lo");
    rdx(3'd6, 8'h00, "R1 unused addr");

    // R2 counting with enable gaps
    run(5);
    for (int i = 0; i < 3; i++) step(0, 0, 3'd0, 8'h00, 0);
    rdx(3'd2, 8'h05, "R2 count");

    // R10 stop holds
    wr(3'd0, 8'h20);
    run(4);
    rdx(3'd2, 8'h05, "R10 stopped");
    wr(3'd0, 8'h00);

    // R9 counter clear beats counting
    step(1, 0, 3'd0, 8'h10, 1);
    rdx(3'd2, 8'h00, "R9 cleared");
    rdx(3'd0, 8'h00, "R9 bit4 reads 0");

    // R4 lone upper write does not change limit
    wr(3'd3, 8'h00);
    rdx(3'd3, 8'h00, "R4 staged readback");
    run(20);
    rdx(3'd2, 8'h14, "R4 old limit still active");
    rdx(3'd4, 8'hFF, "R4 low unchanged");
    rdx(3'd0, 8'h00, "R4 no flag");

    // R3 wrap at committed limit 0x000A
    wr(3'd4, 8'h0A);
    wr(3'd0, 8'h10);
    run(10);
    rdx(3'd2, 8'h0A, "R3 at limit");
    rdx(3'd0, 8'h00, "R3 flag not yet");
    run(1);
    rdx(3'd2, 8'h00, "R3 wrapped");
    rdx(3'd0, 8'h80, "R3 flag set");

    // R6 / R5 interrupt gating
    wr(3'd0, 8'hC0);
    #1 check("R6 irq high", {15'b0, ovf_irq}, 16'h1);
    wr(3'd3, 8'h00);
    #1 check("R5 irq masked while pending", {15'b0, ovf_irq}, 16'h0);
    wr(3'd4, 8'h0A);
    #1 check("R6 irq back", {15'b0, ovf_irq}, 16'h1);

    // R7 clear protocol
    wr(3'd0, 8'hC0);
    wr(3'd0, 8'h40);
    rdx(3'd0, 8'hC0, "R7 no clear without read");
    wr(3'd0, 8'h40);
    rdx(3'd0, 8'h40, "R7 cleared after read");

    // R5 wrap during pending window
    wr(3'd3, 8'h00);
    run(11);
    rdx(3'd2, 8'h00, "R5 wrap still happens");
    rdx(3'd0, 8'h40, "R5 flag held off");
    wr(3'd4, 8'h0A);

    // R8 set wins over clear
    run(11);
    rdx(3'd0, 8'hC0, "R8 flag set, armed");
    run(10);
    step(1, 0, 3'd0, 8'h40, 1);
    rdx(3'd0, 8'hC0, "R8 set beats clear");
    rdx(3'd2, 8'h00, "R8 count wrapped");

    // Random phase against the model
    wr(3'd0, 8'h10);
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [2:0] a;
      logic [7:0] d;
      r = $urandom_range(0, 99);
      a = 3'($urandom_range(0, 5));
      if (r < 55) step(0, 0, 3'd0, 8'h00, 1'($urandom_range(0, 3) != 0));
      else if (r < 80) step(0, 1, a, 8'h00, 1'($urandom_range(0, 1)));
      else if (r < 92) begin
        d = {1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 3) == 0), 4'h0};
        step(1, 0, 3'd0, d, 1'($urandom_range(0, 1)));
      end else if (r < 96) step(1, 0, 3'd3, 8'h00, 1'($urandom_range(0, 1)));
      else step(1, 0, 3'd4, 8'($urandom_range(0, 40)), 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule